// File: doc/BRIEF.md
# Hard-Decision Cyclic-Code Trellis Decoder

This block corrects errors in a received (7,4) binary cyclic codeword whose generator polynomial is 1 + D + D^3 (octal 013). It performs a maximum-likelihood search over the encoder's state diagram, not an algebraic syndrome decode. The state space is the three-bit feedback shift register of the systematic encoder, so there are eight states. Each state keeps a Hamming-distance weight and a survivor path. One add-compare-select unit per state refreshes all eight weights on every received bit.

Bits arrive one per `sym_valid` strobe. The strobe that carries the first bit of a word also raises `sym_first`, and that strobe counts as bit 0. Idle cycles may fall anywhere between strobes. After the seventh bit the decoder reads the state-0 survivor and pulses `dec_done`. It then presents three results: the corrected word, its distance from the received word, and a flag that tells whether that distance lies inside the guaranteed correction radius. The results stay unchanged until the next completion.

The state diagram follows the feedback encoder. From state R the next state is 2R with the top bit dropped, or 2R xor g, where g is the generator with its top bit cleared (g = 3). The input bit and whether R is in the upper half of the state space select which of the two.

Top module: `bch_trellis_dec`

## Requirements
- R1: While reset is high and after it is released with no input, `dec_done`, `dec_word`, `dec_weight` and `dec_ok` are all zero.
- R2: After a complete word, `dec_word` is the codeword nearest in Hamming distance to the received seven bits. `dec_word[6]` holds the first received bit and `dec_word[0]` the last. Every reported word is a multiple of 1 + D + D^3, with `dec_word[6]` as the D^6 coefficient.
- R3: `dec_weight` equals the Hamming distance between the received seven bits and `dec_word`.
- R4: A received word that is already a codeword, such as 1101001 in arrival order, is returned unchanged with weight 0.
- R5: A codeword with any single bit flipped is restored to the original codeword with weight 1.
- R6: `dec_ok` is 1 exactly when twice `dec_weight` is less than the minimum distance 3.
- R7: `dec_done` is high for exactly one cycle. That cycle follows the clock edge that takes the seventh valid bit, counting the `sym_first` strobe as bit 0.
- R8: Cycles with `sym_valid` low are ignored whatever `sym_bit` and `sym_first` carry, so gaps between bits do not change the result.
- R9: Valid strobes without `sym_first` after a word has completed are ignored. No `dec_done` follows, and the outputs keep their values.
- R10: A `sym_first` strobe in the middle of a word discards the partial word and starts a new one at bit 0.
- R11: `dec_word`, `dec_weight` and `dec_ok` change only on the edge that raises `dec_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | Received bit strobe |
| sym_first | input | 1 | Marks the strobe carrying bit 0 of a word |
| sym_bit | input | 1 | Received hard-decision bit |
| dec_done | output | 1 | One-cycle completion pulse |
| dec_word | output | 7 | Corrected codeword, first bit in the MSB |
| dec_weight | output | 3 | Distance between the received bits and the corrected word |
| dec_ok | output | 1 | Distance lies inside the correction radius |

## Verification
Every result is registered on the same edge that consumes the seventh valid bit. The bench therefore drives inputs on falling edges and samples `dec_done` and the three results at the falling edge just after that last strobe. One falling edge later it checks that `dec_done` has dropped and that the results have held. Throughout a word the bench also confirms that `dec_done` stays low at every falling edge. The expected word and weight come from a bench function that tries all sixteen codewords and keeps the nearest one. The checker in the RTL counts valid strobes since the last start marker, so it can confirm that each pulse follows the seventh bit.

// File: rtl/bch_vit_pkg.sv
package bch_vit_pkg;

    // Default code: (7,4) cyclic, generator 1 + D + D^3
    localparam int CODE_N    = 7;
    localparam int CODE_K    = 4;
    localparam int CODE_GEN  = 'o13;
    localparam int CODE_DMIN = 3;
    localparam int WT_W      = 3;

    // Bit-sequencer mode
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_mode_e;

    // Outcome of one compare-select
    typedef struct packed {
        logic take_hi;   // upper predecessor won
        logic code_bit;  // hypothesised code bit on the winning branch
    } acs_pick_t;

    // Number of bits needed to count 0..n
    function automatic int cnt_bits(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/bch_bit_seq.sv
module bch_bit_seq
    import bch_vit_pkg::*;
#(
    parameter int N = CODE_N
) (
    input  logic clk,
    input  logic rst,
    input  logic sym_valid,
    input  logic sym_first,
    output logic step,
    output logic load,
    output logic last
);
    localparam int CW = cnt_bits(N);

    seq_mode_e       mode_q;
    logic [CW-1:0]   cnt_q;
    logic [CW-1:0]   idx;

    always_comb begin
        load = sym_valid & sym_first;
        step = sym_valid & (sym_first | (mode_q == SEQ_RUN));
        idx  = sym_first ? '0 : cnt_q;
        last = step & (idx == CW'(N - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= SEQ_IDLE;
            cnt_q  <= '0;
        end else if (step) begin
            if (last) begin
                mode_q <= SEQ_IDLE;
                cnt_q  <= '0;
            end else begin
                mode_q <= SEQ_RUN;
                cnt_q  <= idx + CW'(1);
            end
        end
    end

endmodule

// File: rtl/bch_acs.sv
module bch_acs
    import bch_vit_pkg::*;
#(
    parameter int WW = WT_W,
    parameter int PW = CODE_N
) (
    input  logic [WW-1:0] w_lo,
    input  logic [WW-1:0] w_hi,
    input  logic [PW-1:0] p_lo,
    input  logic [PW-1:0] p_hi,
    input  logic          hyp_lo,
    input  logic          rx_bit,
    output logic [WW-1:0] w_out,
    output logic [PW-1:0] p_out
);
    function automatic logic [WW-1:0] sat_inc(input logic [WW-1:0] w, input logic c);
        if (c && (w != {WW{1'b1}}))
            return w + WW'(1);
        return w;
    endfunction

    logic [WW-1:0] cand_lo;
    logic [WW-1:0] cand_hi;
    acs_pick_t     pick;

    always_comb begin
        cand_lo       = sat_inc(w_lo, hyp_lo ^ rx_bit);
        cand_hi       = sat_inc(w_hi, ~hyp_lo ^ rx_bit);
        pick.take_hi  = (cand_hi < cand_lo);   // tie keeps the lower predecessor
        pick.code_bit = pick.take_hi ? ~hyp_lo : hyp_lo;
        w_out         = pick.take_hi ? cand_hi : cand_lo;
        p_out         = pick.take_hi ? {p_hi[PW-2:0], pick.code_bit}
                                     : {p_lo[PW-2:0], pick.code_bit};
    end

endmodule

// File: rtl/bch_trellis_dec.sv
module bch_trellis_dec
    import bch_vit_pkg::*;
#(
    parameter int N    = CODE_N,
    parameter int K    = CODE_K,
    parameter int GEN  = CODE_GEN,
    parameter int DMIN = CODE_DMIN,
    parameter int WW   = WT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sym_valid,
    input  logic          sym_first,
    input  logic          sym_bit,
    output logic          dec_done,
    output logic [N-1:0]  dec_word,
    output logic [WW-1:0] dec_weight,
    output logic          dec_ok
);
    localparam int NP  = N - K;
    localparam int NS  = 1 << NP;
    localparam int Q   = NS / 2;
    localparam int GLO = GEN % NS;

    logic step, load, last;

    logic [WW-1:0] wt_q   [NS];
    logic [WW-1:0] wt_cur [NS];
    logic [WW-1:0] wt_nxt [NS];
    logic [N-1:0]  pth_q  [NS];
    logic [N-1:0]  pth_cur[NS];
    logic [N-1:0]  pth_nxt[NS];
    logic [WW+1:0] twice_w;
    logic          ok_nxt;

    bch_bit_seq #(.N(N)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .sym_valid (sym_valid),
        .sym_first (sym_first),
        .step      (step),
        .load      (load),
        .last      (last)
    );

    // Start-of-word metrics: state 0 free, all others penalised by dmin
    always_comb begin
        for (int i = 0; i < NS; i++) begin
            if (load) begin
                wt_cur[i]  = (i == 0) ? '0 : WW'(DMIN);
                pth_cur[i] = '0;
            end else begin
                wt_cur[i]  = wt_q[i];
                pth_cur[i] = pth_q[i];
            end
        end
    end

    // One ACS per successor state; predecessors R and R+Q
    for (genvar s = 0; s < NS; s++) begin : g_state
        localparam int R = ((s % 2) == 0) ? (s / 2) : ((s ^ GLO) / 2);
        bch_acs #(.WW(WW), .PW(N)) u_acs (
            .w_lo   (wt_cur[R]),
            .w_hi   (wt_cur[R + Q]),
            .p_lo   (pth_cur[R]),
            .p_hi   (pth_cur[R + Q]),
            .hyp_lo (1'(s % 2)),
            .rx_bit (sym_bit),
            .w_out  (wt_nxt[s]),
            .p_out  (pth_nxt[s])
        );
    end

    always_comb begin
        twice_w = {1'b0, wt_nxt[0], 1'b0};
        ok_nxt  = (twice_w < (WW+2)'(DMIN));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NS; i++) begin
                wt_q[i]  <= '0;
                pth_q[i] <= '0;
            end
            dec_done   <= 1'b0;
            dec_word   <= '0;
            dec_weight <= '0;
            dec_ok     <= 1'b0;
        end else begin
            dec_done <= last;
            if (step) begin
                for (int i = 0; i < NS; i++) begin
                    wt_q[i]  <= wt_nxt[i];
                    pth_q[i] <= pth_nxt[i];
                end
            end
            if (last) begin
                dec_word   <= pth_nxt[0];
                dec_weight <= wt_nxt[0];
                dec_ok     <= ok_nxt;
            end
        end
    end

endmodule

// File: rtl/bch_trellis_chk.sv
module bch_trellis_chk #(
    parameter int N    = 7,
    parameter int K    = 4,
    parameter int GEN  = 'o13,
    parameter int DMIN = 3,
    parameter int WW   = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          sym_valid,
    input logic          sym_first,
    input logic          dec_done,
    input logic [N-1:0]  dec_word,
    input logic [WW-1:0] dec_weight,
    input logic          dec_ok
);
    localparam int NP  = N - K;
    localparam int GLO = GEN % (1 << NP);
    localparam int CW  = $clog2(N + 1) + 1;

    function automatic logic [NP-1:0] poly_rem(input logic [N-1:0] w);
        logic [NP-1:0] r;
        logic          top;
        r = '0;
        for (int i = N - 1; i >= 0; i--) begin
            top = r[NP-1];
            r   = {r[NP-2:0], w[i]};
            if (top) r = r ^ NP'(GLO);
        end
        return r;
    endfunction

    // Valid strobes seen since the latest start marker
    logic [CW-1:0] seen_q;
    always_ff @(posedge clk) begin
        if (rst)
            seen_q <= '0;
        else if (sym_valid && sym_first)
            seen_q <= CW'(1);
        else if (sym_valid && (seen_q != '0) && (seen_q < CW'(N)))
            seen_q <= seen_q + CW'(1);
    end

    AST_WORD_IS_CODEWORD: assert property (@(posedge clk) disable iff (rst)
        dec_done |-> (poly_rem(dec_word) == '0));                                   // R2

    AST_OK_ZERO_WEIGHT: assert property (@(posedge clk) disable iff (rst)
        (dec_done && dec_weight == '0) |-> dec_ok);                                  // R6

    AST_OK_OUTSIDE_RADIUS: assert property (@(posedge clk) disable iff (rst)
        (dec_done && (int'(dec_weight) * 2 >= DMIN)) |-> !dec_ok);                   // R6

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        dec_done |=> !dec_done);                                                     // R7

    AST_DONE_AFTER_N: assert property (@(posedge clk) disable iff (rst)
        dec_done |-> (seen_q == CW'(N)));                                            // R7

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !dec_done |-> ($stable(dec_word) && $stable(dec_weight) && $stable(dec_ok))); // R11

endmodule

bind bch_trellis_dec bch_trellis_chk #(
    .N(N), .K(K), .GEN(GEN), .DMIN(DMIN), .WW(WW)
) u_chk (.*);

// File: tb/tb_bch_trellis_dec.sv
module tb_bch_trellis_dec;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sym_valid = 1'b0;
    logic       sym_first = 1'b0;
    logic       sym_bit = 1'b0;
    logic       dec_done;
    logic [6:0] dec_word;
    logic [2:0] dec_weight;
    logic       dec_ok;

    int n_chk = 0;
    int n_bad = 0;

    logic [6:0] exp_word = '0;
    int         exp_w = 0;
    logic       exp_ok = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    bch_trellis_dec dut (
        .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_first(sym_first),
        .sym_bit(sym_bit), .dec_done(dec_done), .dec_word(dec_word),
        .dec_weight(dec_weight), .dec_ok(dec_ok)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Codeword for message m: carry-less product with 1 + D + D^3
    function automatic logic [6:0] encode(input int m);
        logic [6:0] c = '0;
        for (int b = 0; b < 4; b++)
            if (m[b]) c = c ^ 7'(7'b0001011 << b);
        return c;
    endfunction

    function automatic int nearest(input logic [6:0] rx, output logic [6:0] best);
        int bd = 99;
        best = '0;
        for (int m = 0; m < 16; m++) begin
            logic [6:0] c = encode(m);
            int d = $countones(rx ^ c);
            if (d < bd) begin
                bd = d;
                best = c;
            end
        end
        return bd;
    endfunction

    task automatic idle_gap(input int ncyc);
        for (int j = 0; j < ncyc; j++) begin
            @(negedge clk);
            sym_valid = 1'b0;
            sym_first = 1'($urandom);
            sym_bit   = 1'($urandom);
        end
    endtask

    // Sends a word, first bit = rx[6]; checks result timing and hold
    task automatic send_word(input logic [6:0] rx, input int gap_max, input string tag);
        int early = 0;
        exp_w  = nearest(rx, exp_word);
        exp_ok = (exp_w * 2 < 3);
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            if (dec_done) early++;
            sym_valid = 1'b1;
            sym_first = (i == 0);
            sym_bit   = rx[6 - i];
            if (gap_max > 0 && i < 6) idle_gap($urandom_range(gap_max, 0));
        end
        @(negedge clk);
        sym_valid = 1'b0;
        sym_first = 1'b0;
        check({"R7 no early done ", tag}, early, 0);
        check({"R7 done after last bit ", tag}, int'(dec_done), 1);
        check({"R2 word ", tag}, int'(dec_word), int'(exp_word));
        check({"R3 weight ", tag}, int'(dec_weight), exp_w);
        check({"R6 ok flag ", tag}, int'(dec_ok), int'(exp_ok));
        @(negedge clk);
        check({"R7 done drops ", tag}, int'(dec_done), 0);
        check({"R11 word held ", tag}, int'(dec_word), int'(exp_word));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 done in reset", int'(dec_done), 0);
        check("R1 word in reset", int'(dec_word), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 done after reset", int'(dec_done), 0);
        check("R1 weight after reset", int'(dec_weight), 0);
        check("R1 ok after reset", int'(dec_ok), 0);

        // R4: clean codewords
        send_word(7'b1101001, 0, "R4 clean 1101001");
        check("R4 weight zero", int'(dec_weight), 0);
        send_word(7'b0000000, 0, "R4 all zero");
        send_word(encode(15), 0, "R4 msg 15");

        // R5: every single-bit error on 1101001
        for (int e = 0; e < 7; e++) begin
            logic [6:0] rx = 7'b1101001 ^ 7'(1 << e);
            send_word(rx, 0, "R5 single error");
            check("R5 restored", int'(dec_word), int'(7'b1101001));
            check("R5 weight one", int'(dec_weight), 1);
        end

        // R8: gaps with garbage on idle cycles
        send_word(7'b1101001 ^ 7'b0010000, 3, "R8 gaps");
        send_word(encode(6), 4, "R8 gaps clean");

        // R9: strobes without a start marker after completion
        begin
            int extra = 0;
            for (int i = 0; i < 9; i++) begin
                @(negedge clk);
                if (dec_done) extra++;
                sym_valid = 1'b1;
                sym_first = 1'b0;
                sym_bit   = 1'($urandom);
            end
            @(negedge clk);
            sym_valid = 1'b0;
            if (dec_done) extra++;
            @(negedge clk);
            if (dec_done) extra++;
            check("R9 no done from stray bits", extra, 0);
            check("R9 word kept", int'(dec_word), int'(exp_word));
            check("R9 weight kept", exp_w, int'(dec_weight));
        end

        // R10: restart mid-word
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            sym_valid = 1'b1;
            sym_first = (i == 0);
            sym_bit   = 1'b1;
        end
        send_word(encode(9) ^ 7'b0000100, 0, "R10 restart");
        check("R10 restarted word", int'(dec_word), int'(encode(9)));

        // Random traffic: codewords with 0 or 1 flip, and arbitrary words
        for (int t = 0; t < 150; t++) begin
            logic [6:0] rx;
            int e;
            if (t % 3 == 2) begin
                rx = 7'($urandom);
            end else begin
                rx = encode($urandom_range(15, 0));
                e  = $urandom_range(7, 0);
                if (e < 7) rx = rx ^ 7'(1 << e);
            end
            send_word(rx, (t % 4 == 0) ? 2 : 0, "R2 R3 R6 random");
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule